// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sits next to a simple in-order core and owns the architectural state that changes when the core takes a trap. The core reports events on a few request inputs:

- a synchronous exception with a major cause code and a translation-refill flag;
- a bus error that is marked as either an instruction fetch or a data access;
- a debug breakpoint;
- thirteen level-sensitive interrupt lines.

With each event the core also supplies the faulting PC and the instruction word. The block decides which entry path applies and updates the matching saved-state registers. It then issues a redirect PC with a one-cycle strobe.

There are three entry paths, and each one saves into its own register set. The normal path covers exceptions and interrupts, with vector slots spaced by a programmable stride. The refill path jumps to its own entry address and forces direct-address mode. The debug path covers breakpoints and interrupts that arrive while the debug-state flag is set. A flat register-access port lets the core read and write the control registers.

Top module: `exc_entry_ctrl`

## Requirements
- R1: An interrupt is taken only when CUR.ie (bit 2 of register 0) is 1, DBG.dst (bit 2 of register 11) is 0, and the pending bits ANDed with CFG.lie (register 3 bits 12:0) are nonzero. Any synchronous request in the same cycle is taken instead, and the interrupt waits.
- R2: Each interrupt line i is copied every clock into pending bit i of STAT (register 2, bits 12:0), one cycle after the line changes. Writes to STAT have no effect.
- R3: For an interrupt, the highest-numbered bit of (pending AND lie) selects vector v. The redirect target is EENTRY (register 7) + (64 + v) × stride. STAT.major (bits 21:16) becomes 0, and ERA (register 4) takes the PC input.
- R4: The stride is 0 when CFG.vs (register 3 bits 18:16) is 0. Otherwise it is (1 << vs) × 4 bytes.
- R5: A non-refill exception does the following:
  - writes its major code to STAT bits 21:16 and its sub code to STAT bits 30:22;
  - copies CUR.plv (bits 1:0) and CUR.ie into PREV (register 1: pplv in bits 1:0, pie in bit 2);
  - saves the PC to ERA and redirects to EENTRY + major × stride.
- R6: A refill exception does the following:
  - copies plv and ie into RPREV (register 8), using the same layout as PREV;
  - sets CUR.da (bit 3) to 1 and CUR.pg (bit 4) to 0;
  - stores PC >> 2 in RERA (register 9) and redirects to RENTRY (register 10);
  - leaves ERA and STAT unchanged.
- R7: Every entry clears CUR.plv and CUR.ie. redirect_valid is high for exactly the one cycle after the accepting clock edge, and redirect_pc holds the target.
- R8: A breakpoint does the following:
  - sets DBG.dcl (bit 0) and DBG.dst, and writes 0xC into DBG.code (bits 21:16);
  - saves the PC into DERA (register 12) and redirects to EENTRY + 0x480;
  - leaves ERA unchanged.
- R9: An interrupt that is enabled while DBG.dst is 1 sets DBG.dei (bit 1), saves the PC to DERA and redirects to EENTRY + 0x480, not to the normal path.
- R10: Major codes 10, 11, 12, 13, 14, 15 and 18 load BADV (register 5) with the PC. BADI (register 6) takes the instruction word for every exception except these: code 3, code 8 with sub code 0, and interrupts.
- R11: A bus error raises major code 8, with sub code 0 for a fetch and 1 for a data access. When requests arrive in the same cycle, a breakpoint is taken before a bus error, and a bus error before an exception request.
- R12: After reset:
  - redirect_pc is 0x1C000000 and redirect_valid is 0;
  - CUR reads 0x08 (plv 0, ie 0, da 1, pg 0);
  - CFG and STAT read 0.
- R13: Registers 0, 1, 3, 4, 5, 7, 8, 10, 11 and 12 accept writes through the access port. Reads return the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_IRQ | Level interrupt lines |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | CODE_W | Major cause code of the request |
| exc_refill | input | 1 | Request uses the refill path |
| exc_pc | input | AW | PC of the faulting or interrupted instruction |
| exc_insn | input | INSN_W | Instruction word at exc_pc |
| bkpt_req | input | 1 | Debug breakpoint request |
| buserr_req | input | 1 | Bus error request |
| buserr_fetch | input | 1 | Bus error came from an instruction fetch |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Register index |
| csr_wdata | input | AW | Register write data |
| csr_rdata | output | AW | Register read data |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | AW | Redirect target |

## Verification
The assertions assume the following about the inputs:
- request signals are free of X after reset;
- interrupt lines are sampled only at the clock;
- the core does not raise a refill request together with a breakpoint or a bus error and expect the refill to win.

The stimulus stays within these assumptions. It drives all inputs half a cycle away from the active edge, and it draws exception codes only from the defined set. It raises simultaneous requests only in directed cases whose priority outcome is written into the requirements. Random interrupt patterns always include at least one line that is both pending and enabled, so each armed case is expected to be taken.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef struct packed {
      logic       pg;
      logic       da;
      logic       ie;
      logic [1:0] plv;
   } cur_mode_t;

   typedef struct packed {
      logic       pie;
      logic [1:0] pplv;
   } prev_mode_t;

   localparam logic [5:0] CODE_PAGE_LD    = 6'd1;
   localparam logic [5:0] CODE_PAGE_FETCH = 6'd3;
   localparam logic [5:0] CODE_ADDR_ERR   = 6'd8;
   localparam logic [5:0] CODE_BOUND      = 6'd10;
   localparam logic [5:0] CODE_SYSCALL    = 6'd11;
   localparam logic [5:0] CODE_BREAK      = 6'd12;
   localparam logic [5:0] CODE_ILLEGAL    = 6'd13;
   localparam logic [5:0] CODE_PRIV_INSN  = 6'd14;
   localparam logic [5:0] CODE_FP_OFF     = 6'd15;
   localparam logic [5:0] CODE_FP_EXC     = 6'd18;
   localparam logic [5:0] CODE_DEBUG_BP   = 6'hC;

   typedef enum logic [3:0] {
      RA_CUR    = 4'd0,
      RA_PREV   = 4'd1,
      RA_STAT   = 4'd2,
      RA_CFG    = 4'd3,
      RA_ERA    = 4'd4,
      RA_BADV   = 4'd5,
      RA_BADI   = 4'd6,
      RA_EENTRY = 4'd7,
      RA_RPREV  = 4'd8,
      RA_RERA   = 4'd9,
      RA_RENTRY = 4'd10,
      RA_DBG    = 4'd11,
      RA_DERA   = 4'd12
   } reg_addr_e;

endpackage

// File: rtl/exc_irq_pick.sv
module exc_irq_pick #(
   parameter int NUM_IRQ = 13,
   localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic [NUM_IRQ-1:0] pend,
   input  logic [NUM_IRQ-1:0] mask,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   logic [NUM_IRQ-1:0] live;
   assign live = pend & mask;
   assign any  = |live;

   // later (higher) lines overwrite earlier ones: highest number wins
   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (live[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/exc_vec_offset.sv
module exc_vec_offset #(
   parameter int AW    = 32,
   parameter int VS_W  = 3,
   parameter int SLOT_W = 7
) (
   input  logic [VS_W-1:0]   vs,
   input  logic [SLOT_W-1:0] slot,
   output logic [AW-1:0]     offset
);
   logic [VS_W:0]   shamt;
   logic [AW-1:0]   slot_ext;

   assign shamt    = {1'b0, vs} + (VS_W+1)'(2);
   assign slot_ext = AW'(slot);
   assign offset   = (vs == '0) ? '0 : (slot_ext << shamt);
endmodule

// File: rtl/exc_cause_class.sv
module exc_cause_class
   import exc_entry_pkg::*;
#(
   parameter int CODE_W = 6
) (
   input  logic [CODE_W-1:0] major,
   input  logic              data_side,
   output logic              take_badv,
   output logic              take_badi
);
   always_comb begin
      unique case (major)
         CODE_BOUND, CODE_SYSCALL, CODE_BREAK, CODE_ILLEGAL,
         CODE_PRIV_INSN, CODE_FP_OFF, CODE_FP_EXC: take_badv = 1'b1;
         default:                                  take_badv = 1'b0;
      endcase
   end

   assign take_badi = !((major == CODE_PAGE_FETCH) ||
                        ((major == CODE_ADDR_ERR) && !data_side));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int          AW        = 32,
   parameter int          INSN_W    = 32,
   parameter int          NUM_IRQ   = 13,
   parameter int          CODE_W    = 6,
   parameter int          SUB_W     = 9,
   parameter int          VS_W      = 3,
   parameter int          CSR_AW    = 4,
   parameter int          IRQ_BASE  = 64,
   parameter logic [31:0] DBG_OFF   = 32'h480,
   parameter logic [31:0] RESET_PC  = 32'h1C00_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_lines,
   input  logic               exc_req,
   input  logic [CODE_W-1:0]  exc_code,
   input  logic               exc_refill,
   input  logic [AW-1:0]      exc_pc,
   input  logic [INSN_W-1:0]  exc_insn,
   input  logic               bkpt_req,
   input  logic               buserr_req,
   input  logic               buserr_fetch,
   input  logic               csr_we,
   input  logic [CSR_AW-1:0]  csr_addr,
   input  logic [AW-1:0]      csr_wdata,
   output logic [AW-1:0]      csr_rdata,
   output logic               redirect_valid,
   output logic [AW-1:0]      redirect_pc
);
   localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
   localparam int SLOT_W  = $clog2(IRQ_BASE + NUM_IRQ + 1);
   localparam int STAT_MJ = 16;
   localparam int STAT_SB = STAT_MJ + CODE_W;
   localparam int CFG_VS  = 16;

   generate
      if (AW < 32) begin : g_bad_aw
         $error("exc_entry_ctrl: AW must be at least 32");
      end
      if (NUM_IRQ < 1 || NUM_IRQ > STAT_MJ) begin : g_bad_irq
         $error("exc_entry_ctrl: NUM_IRQ must lie in 1..16");
      end
      if (STAT_SB + SUB_W > AW) begin : g_bad_stat
         $error("exc_entry_ctrl: status fields exceed AW");
      end
      if (CFG_VS + VS_W > AW) begin : g_bad_cfg
         $error("exc_entry_ctrl: vector-size field exceeds AW");
      end
   endgenerate

   // architectural state
   cur_mode_t          mode_q;
   prev_mode_t         prev_q, rprev_q;
   logic [NUM_IRQ-1:0] pend_q, lie_q;
   logic [VS_W-1:0]    vs_q;
   logic [CODE_W-1:0]  major_q;
   logic [SUB_W-1:0]   sub_q;
   logic [AW-1:0]      era_q, badv_q, eentry_q, rentry_q, dera_q;
   logic [INSN_W-1:0]  badi_q;
   logic [AW-3:0]      rera_q;
   logic               dcl_q, dei_q, dst_q;
   logic [CODE_W-1:0]  dcode_q;
   logic               rv_q;
   logic [AW-1:0]      rpc_q;

   // event decode
   logic               irq_any;
   logic [IDX_W-1:0]   irq_idx;
   logic               take_bp, take_bus, take_exc, sync_any;
   logic               irq_ok, take_irq_norm, take_irq_dbg;
   logic               take_refill, take_normal, take_debug, any_event;
   logic [CODE_W-1:0]  ev_major;
   logic [SUB_W-1:0]   ev_sub;
   logic               cls_badv, cls_badi;
   logic [SLOT_W-1:0]  slot;
   logic [AW-1:0]      vec_off, target;

   exc_irq_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
      .pend (pend_q),
      .mask (lie_q),
      .any  (irq_any),
      .idx  (irq_idx)
   );

   assign take_bp   = bkpt_req;
   assign take_bus  = !bkpt_req && buserr_req;
   assign take_exc  = !bkpt_req && !buserr_req && exc_req;
   assign sync_any  = bkpt_req || buserr_req || exc_req;

   assign irq_ok        = !sync_any && mode_q.ie && irq_any;
   assign take_irq_norm = irq_ok && !dst_q;
   assign take_irq_dbg  = irq_ok && dst_q;

   assign take_refill = take_exc && exc_refill;
   assign take_normal = take_bus || (take_exc && !exc_refill) || take_irq_norm;
   assign take_debug  = take_bp || take_irq_dbg;
   assign any_event   = take_normal || take_refill || take_debug;

   assign ev_major = take_bus ? CODE_ADDR_ERR : (take_exc ? exc_code : '0);
   assign ev_sub   = take_bus ? SUB_W'(!buserr_fetch) : '0;

   exc_cause_class #(.CODE_W(CODE_W)) u_class (
      .major     (ev_major),
      .data_side (ev_sub[0]),
      .take_badv (cls_badv),
      .take_badi (cls_badi)
   );

   assign slot = take_irq_norm ? SLOT_W'(IRQ_BASE) + SLOT_W'(irq_idx)
                               : SLOT_W'(ev_major);

   exc_vec_offset #(.AW(AW), .VS_W(VS_W), .SLOT_W(SLOT_W)) u_off (
      .vs     (vs_q),
      .slot   (slot),
      .offset (vec_off)
   );

   always_comb begin
      if (take_debug)       target = eentry_q + AW'(DBG_OFF);
      else if (take_refill) target = rentry_q;
      else                  target = eentry_q + vec_off;
   end

   // register update: software writes first, entry effects override
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '{pg: 1'b0, da: 1'b1, ie: 1'b0, plv: 2'd0};
         prev_q   <= '0;
         rprev_q  <= '0;
         pend_q   <= '0;
         lie_q    <= '0;
         vs_q     <= '0;
         major_q  <= '0;
         sub_q    <= '0;
         era_q    <= '0;
         badv_q   <= '0;
         badi_q   <= '0;
         eentry_q <= '0;
         rentry_q <= '0;
         rera_q   <= '0;
         dera_q   <= '0;
         dcl_q    <= 1'b0;
         dei_q    <= 1'b0;
         dst_q    <= 1'b0;
         dcode_q  <= '0;
         rv_q     <= 1'b0;
         rpc_q    <= AW'(RESET_PC);
      end else begin
         pend_q <= irq_lines;
         rv_q   <= any_event;

         if (csr_we) begin
            unique case (csr_addr)
               CSR_AW'(RA_CUR):    mode_q   <= cur_mode_t'(csr_wdata[4:0]);
               CSR_AW'(RA_PREV):   prev_q   <= prev_mode_t'(csr_wdata[2:0]);
               CSR_AW'(RA_CFG): begin
                  lie_q <= csr_wdata[NUM_IRQ-1:0];
                  vs_q  <= csr_wdata[CFG_VS +: VS_W];
               end
               CSR_AW'(RA_ERA):    era_q    <= csr_wdata;
               CSR_AW'(RA_BADV):   badv_q   <= csr_wdata;
               CSR_AW'(RA_EENTRY): eentry_q <= csr_wdata;
               CSR_AW'(RA_RPREV):  rprev_q  <= prev_mode_t'(csr_wdata[2:0]);
               CSR_AW'(RA_RENTRY): rentry_q <= csr_wdata;
               CSR_AW'(RA_DBG): begin
                  dcl_q   <= csr_wdata[0];
                  dei_q   <= csr_wdata[1];
                  dst_q   <= csr_wdata[2];
                  dcode_q <= csr_wdata[STAT_MJ +: CODE_W];
               end
               CSR_AW'(RA_DERA):   dera_q   <= csr_wdata;
               default: ;
            endcase
         end

         if (any_event) begin
            rpc_q      <= target;
            mode_q.plv <= 2'd0;
            mode_q.ie  <= 1'b0;
         end

         if (take_normal) begin
            major_q <= ev_major;
            sub_q   <= ev_sub;
            prev_q  <= '{pie: mode_q.ie, pplv: mode_q.plv};
            era_q   <= exc_pc;
         end

         if (take_refill) begin
            rprev_q   <= '{pie: mode_q.ie, pplv: mode_q.plv};
            mode_q.da <= 1'b1;
            mode_q.pg <= 1'b0;
            rera_q    <= exc_pc[AW-1:2];
         end

         if (take_debug) begin
            dera_q <= exc_pc;
            dst_q  <= 1'b1;
            if (take_bp) begin
               dcl_q   <= 1'b1;
               dcode_q <= CODE_W'(CODE_DEBUG_BP);
            end else begin
               dei_q   <= 1'b1;
            end
         end

         if (take_exc && cls_badv) badv_q <= exc_pc;
         if ((take_exc || take_bus) && cls_badi) badi_q <= exc_insn;
      end
   end

   // read mux
   always_comb begin
      csr_rdata = '0;
      unique case (csr_addr)
         CSR_AW'(RA_CUR):    csr_rdata[4:0] = mode_q;
         CSR_AW'(RA_PREV):   csr_rdata[2:0] = prev_q;
         CSR_AW'(RA_STAT): begin
            csr_rdata[NUM_IRQ-1:0]       = pend_q;
            csr_rdata[STAT_MJ +: CODE_W] = major_q;
            csr_rdata[STAT_SB +: SUB_W]  = sub_q;
         end
         CSR_AW'(RA_CFG): begin
            csr_rdata[NUM_IRQ-1:0]     = lie_q;
            csr_rdata[CFG_VS +: VS_W]  = vs_q;
         end
         CSR_AW'(RA_ERA):    csr_rdata = era_q;
         CSR_AW'(RA_BADV):   csr_rdata = badv_q;
         CSR_AW'(RA_BADI):   csr_rdata = AW'(badi_q);
         CSR_AW'(RA_EENTRY): csr_rdata = eentry_q;
         CSR_AW'(RA_RPREV):  csr_rdata[2:0] = rprev_q;
         CSR_AW'(RA_RERA):   csr_rdata = AW'(rera_q);
         CSR_AW'(RA_RENTRY): csr_rdata = rentry_q;
         CSR_AW'(RA_DBG): begin
            csr_rdata[0] = dcl_q;
            csr_rdata[1] = dei_q;
            csr_rdata[2] = dst_q;
            csr_rdata[STAT_MJ +: CODE_W] = dcode_q;
         end
         CSR_AW'(RA_DERA):   csr_rdata = dera_q;
         default: ;
      endcase
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^csr_wdata;

   assign redirect_valid = rv_q;
   assign redirect_pc    = rpc_q;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
   import exc_entry_pkg::*;
#(
   parameter int NUM_IRQ = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] irq_lines,
   input logic               exc_req,
   input logic               exc_refill,
   input logic               bkpt_req,
   input logic               buserr_req,
   input logic               redirect_valid,
   input cur_mode_t          cur,
   input logic [NUM_IRQ-1:0] pend,
   input logic               dst
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_entry_clears_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (cur.plv == 2'd0 && !cur.ie));

   p_pending_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (pend == $past(irq_lines)));

   p_irq_needs_ie_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && redirect_valid && !$past(bkpt_req || buserr_req || exc_req))
         |-> $past(cur.ie));

   p_bkpt_debug_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(bkpt_req)) |-> (redirect_valid && dst));

   p_refill_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(exc_req && exc_refill && !bkpt_req && !buserr_req))
         |-> (cur.da && !cur.pg));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .irq_lines      (irq_lines),
   .exc_req        (exc_req),
   .exc_refill     (exc_refill),
   .bkpt_req       (bkpt_req),
   .buserr_req     (buserr_req),
   .redirect_valid (redirect_valid),
   .cur            (mode_q),
   .pend           (pend_q),
   .dst            (dst_q)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
   localparam logic [3:0] A_CUR = 0, A_PREV = 1, A_STAT = 2, A_CFG = 3, A_ERA = 4,
                          A_BADV = 5, A_BADI = 6, A_EENTRY = 7, A_RPREV = 8,
                          A_RERA = 9, A_RENTRY = 10, A_DBG = 11, A_DERA = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] irq_lines = '0;
   logic        exc_req = 0, exc_refill = 0, bkpt_req = 0, buserr_req = 0, buserr_fetch = 0;
   logic [5:0]  exc_code = '0;
   logic [31:0] exc_pc = '0, exc_insn = '0;
   logic        csr_we = 0;
   logic [3:0]  csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        redirect_valid;
   logic [31:0] redirect_pc;

   int tests = 0, fails = 0;
   logic [31:0] exp_badi = '0;

   always #2.5 clk = ~clk;

   exc_entry_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .exc_req(exc_req),
      .exc_code(exc_code), .exc_refill(exc_refill), .exc_pc(exc_pc),
      .exc_insn(exc_insn), .bkpt_req(bkpt_req), .buserr_req(buserr_req),
      .buserr_fetch(buserr_fetch), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
   );

   function automatic logic [31:0] stride(input logic [2:0] vs);
      return (vs == 0) ? 32'd0 : (32'd4 << vs);
   endfunction

   function automatic int hi_bit(input logic [12:0] m);
      int h = -1;
      for (int i = 0; i < 13; i++) if (m[i]) h = i;
      return h;
   endfunction

   function automatic bit badv_class(input logic [5:0] c);
      return (c == 10 || c == 11 || c == 12 || c == 13 || c == 14 || c == 15 || c == 18);
   endfunction

   function automatic bit badi_class(input logic [5:0] c, input bit data);
      return !(c == 3 || (c == 8 && !data));
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      csr_addr = a; csr_wdata = d; csr_we = 1'b1;
      tick();
      csr_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      csr_addr = a;
      #0.5;
      d = csr_rdata;
   endtask

   task automatic fire(input bit bp, input bit bus, input bit bfetch, input bit ex,
                       input logic [5:0] code, input bit rf,
                       input logic [31:0] pc, input logic [31:0] insn);
      bkpt_req = bp; buserr_req = bus; buserr_fetch = bfetch; exc_req = ex;
      exc_code = code; exc_refill = rf; exc_pc = pc; exc_insn = insn;
      tick();
      bkpt_req = 0; buserr_req = 0; exc_req = 0; exc_refill = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, ee, pc, ins, era_keep;
      logic [5:0]  codes [15] = '{1,2,3,4,5,6,7,8,10,11,12,13,14,15,18};
      void'($urandom(32'd7301));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 redirect_pc", redirect_pc, 32'h1C00_0000);
      chk("R12 redirect_valid", {31'd0, redirect_valid}, 32'd0);
      rd(A_CUR, d);  chk("R12 cur", d, 32'h08);
      rd(A_CFG, d);  chk("R12 cfg", d, 32'h0);
      rd(A_STAT, d); chk("R12 stat", d, 32'h0);

      // R2 pending follows lines, writes ignored
      irq_lines = 13'h1005;
      tick();
      rd(A_STAT, d); chk("R2 pending", d & 32'h1FFF, 32'h1005);
      wr(A_STAT, 32'h0000_0FFF);
      rd(A_STAT, d); chk("R2 write ignored", d & 32'h1FFF, 32'h1005);

      // R1 masked or disabled: no entry
      wr(A_EENTRY, 32'h8000_0000);
      wr(A_CFG, (32'd2 << 16) | 32'h0002);
      wr(A_CUR, 32'h0C);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R1 masked no entry", {31'd0, redirect_valid}, 32'd0);
      end
      wr(A_CUR, 32'h08);
      wr(A_CFG, (32'd2 << 16) | 32'h1FFF);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R1 ie clear no entry", {31'd0, redirect_valid}, 32'd0);
      end

      // R1/R11 sync request beats pending interrupt
      exc_pc = 32'h0000_4000;
      wr(A_CUR, 32'h0F);
      fire(0, 0, 0, 1, 6'd13, 0, 32'h0000_4000, 32'h1111_2222);
      exp_badi = 32'h1111_2222;
      chk("R11 sync before irq", redirect_pc, 32'h8000_0000 + 13 * 16);
      rd(A_STAT, d); chk("R5 major 13", (d >> 16) & 32'h3F, 32'd13);

      // R3 interrupt vector, ie set while pending
      exc_pc = 32'h0000_5550;
      wr(A_CUR, 32'h0E);
      tick();
      chk("R3 irq strobe", {31'd0, redirect_valid}, 32'd1);
      chk("R3 irq target", redirect_pc, 32'h8000_0000 + (64 + 12) * 16);
      rd(A_ERA, d);  chk("R3 era", d, 32'h0000_5550);
      rd(A_STAT, d); chk("R3 major 0", (d >> 16) & 32'h3F, 32'd0);
      rd(A_PREV, d); chk("R5 prev from irq", d, 32'h6);
      tick();
      chk("R7 strobe one cycle", {31'd0, redirect_valid}, 32'd0);
      irq_lines = '0;
      tick();

      // R4 stride zero
      wr(A_CFG, 32'h0);
      fire(0, 0, 0, 1, 6'd11, 0, 32'h0000_6000, 32'h3333_4444);
      exp_badi = 32'h3333_4444;
      chk("R4 vs0 target", redirect_pc, 32'h8000_0000);

      // R5/R10 random exceptions
      for (int k = 0; k < 60; k++) begin
         logic [5:0] c; logic [2:0] vs; logic [1:0] plv; bit ie;
         c = codes[$urandom_range(0, 14)];
         vs = 3'($urandom_range(0, 7));
         plv = 2'($urandom_range(0, 3));
         ie = 1'($urandom_range(0, 1));
         ee = $urandom & 32'hFFFF_F000;
         pc = $urandom & 32'hFFFF_FFFC;
         ins = $urandom;
         wr(A_CFG, 32'(vs) << 16);
         wr(A_EENTRY, ee);
         wr(A_CUR, 32'h08 | (32'(ie) << 2) | 32'(plv));
         wr(A_BADV, 32'h5A5A_0000 | k);
         fire(0, 0, 0, 1, c, 0, pc, ins);
         if (badi_class(c, 1'b0)) exp_badi = ins;
         chk("R5 target", redirect_pc, ee + 32'(c) * stride(vs));
         rd(A_ERA, d);  chk("R5 era", d, pc);
         rd(A_PREV, d); chk("R5 prev", d, (32'(ie) << 2) | 32'(plv));
         rd(A_STAT, d); chk("R5 major", (d >> 16) & 32'h3F, 32'(c));
         rd(A_CUR, d);  chk("R7 cur cleared", d, 32'h08);
         rd(A_BADV, d); chk("R10 badv", d, badv_class(c) ? pc : (32'h5A5A_0000 | k));
         rd(A_BADI, d); chk("R10 badi", d, exp_badi);
      end

      // R3 random interrupts
      for (int k = 0; k < 20; k++) begin
         logic [12:0] ln, le; logic [2:0] vs;
         ln = 13'($urandom) | 13'h1;
         le = 13'($urandom);
         if ((ln & le) == 0) le = le | ln;
         vs = 3'($urandom_range(1, 7));
         ee = $urandom & 32'hFFFF_F000;
         wr(A_CUR, 32'h08);
         irq_lines = ln;
         wr(A_CFG, (32'(vs) << 16) | 32'(le));
         wr(A_EENTRY, ee);
         exc_pc = 32'h0001_0000 + 32'(k * 4);
         wr(A_CUR, 32'h0D);
         tick();
         chk("R3 rand strobe", {31'd0, redirect_valid}, 32'd1);
         chk("R3 rand target", redirect_pc, ee + 32'(64 + hi_bit(ln & le)) * stride(vs));
         irq_lines = '0;
         tick();
      end

      // R6 refill
      ee = 32'h4000_0000;
      wr(A_EENTRY, ee);
      wr(A_CFG, 32'd1 << 16);
      rd(A_ERA, era_keep);
      wr(A_RENTRY, 32'h9000_0100);
      wr(A_CUR, 32'h16);
      fire(0, 0, 0, 1, 6'd1, 1, 32'h2000_0010, 32'h7777_0001);
      exp_badi = 32'h7777_0001;
      chk("R6 refill target", redirect_pc, 32'h9000_0100);
      rd(A_RERA, d);  chk("R6 rera", d, 32'h0800_0004);
      rd(A_RPREV, d); chk("R6 rprev", d, 32'h6);
      rd(A_CUR, d);   chk("R6 cur da/pg", d, 32'h08);
      rd(A_ERA, d);   chk("R6 era kept", d, era_keep);

      // R11 bus errors
      fire(0, 1, 1, 0, 6'd0, 0, 32'h0000_7000, 32'hAAAA_0001);
      chk("R11 fetch target", redirect_pc, ee + 8 * 8);
      rd(A_STAT, d); chk("R11 fetch code", d >> 16, 32'h0008);
      rd(A_BADI, d); chk("R10 fetch badi kept", d, exp_badi);
      fire(0, 1, 0, 0, 6'd0, 0, 32'h0000_7004, 32'hAAAA_0002);
      rd(A_STAT, d); chk("R11 data code", d >> 16, 32'h0048);
      rd(A_BADI, d); chk("R10 data badi", d, 32'hAAAA_0002);

      // R8 breakpoint with all requests at once
      rd(A_ERA, era_keep);
      fire(1, 1, 0, 1, 6'd11, 0, 32'h0000_8000, 32'h0);
      chk("R8 debug target", redirect_pc, ee + 32'h480);
      rd(A_DBG, d);  chk("R8 dbg", d, 32'h000C_0005);
      rd(A_DERA, d); chk("R8 dera", d, 32'h0000_8000);
      rd(A_ERA, d);  chk("R11 bp wins era kept", d, era_keep);

      // R9 interrupt in debug state
      irq_lines = 13'h0004;
      wr(A_CFG, (32'd1 << 16) | 32'h0004);
      exc_pc = 32'h0000_9000;
      wr(A_CUR, 32'h0C);
      tick();
      chk("R9 debug irq target", redirect_pc, ee + 32'h480);
      rd(A_DBG, d);  chk("R9 dei", d, 32'h000C_0007);
      rd(A_DERA, d); chk("R9 dera", d, 32'h0000_9000);
      rd(A_ERA, d);  chk("R9 era kept", d, era_keep);
      irq_lines = '0;

      // R13 writable registers read back
      wr(A_DBG, 32'h0);
      rd(A_DBG, d);  chk("R13 dbg write", d, 32'h0);
      wr(A_DERA, 32'h1234_5678);
      rd(A_DERA, d); chk("R13 dera write", d, 32'h1234_5678);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule